// File: doc/BRIEF.md
# Boost Converter Peak-Current PWM Controller

This block drives the power switch of an external boost converter that supplies a half-bridge coil driver. Each switching cycle turns the switch on and ends the on-phase either when an external peak-current comparator trips or when a programmable maximum on-time expires. A programmable minimum off-time always separates two on-phases. The comparator output is ignored for a short blanking window after each turn-on, which masks the current spike at turn-on.

Two start rules are available. In fixed-frequency mode a free-running period counter issues a tick, and the tick starts a cycle. In quasi-resonant mode, which suits medium and light load, the next on-phase waits for a rising edge on the inductor demagnetization input. If that edge does not come within a timeout, the block forces a cycle and counts the event. Both asynchronous inputs pass through multi-flop synchronizers.

The block also generates a PWM output whose duty cycle is low-pass filtered outside the chip to form the converter's voltage reference. The duty setting is double-buffered. A new value takes effect only at the next boundary of the reference PWM period.

Top module: `boost_pcm_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `sw_drv` is 0, `ref_pwm` is 0 and `qr_force_cnt` is 0.
- R2: An on-phase never lasts more than `cfg_ton_max` cycles. With the comparator input held low, it lasts exactly `cfg_ton_max` cycles.
- R3: A comparator trip is ignored for the first `cfg_blank` cycles of an on-phase. With `cmp_trip_a` held high, the on-phase lasts min(`cfg_blank`+1, `cfg_ton_max`) cycles.
- R4: In fixed-frequency mode (`cfg_qr_en`=0), the switch turns on at a period tick, giving a rise-to-rise interval of `cfg_period` cycles. If the switch has been off for fewer than `cfg_toff_min` cycles when a tick arrives, that tick is skipped and the interval doubles.
- R5: In quasi-resonant mode (`cfg_qr_en`=1), a rising edge on `demag_a` turns the switch on; `sw_drv` is 1 at the third clock edge after `demag_a` rises. The edge is honoured only once the switch has been off for at least `cfg_toff_min` cycles. An edge that arrives earlier is ignored and is not remembered.
- R6: In quasi-resonant mode, if no usable demagnetization edge arrives, the switch is forced on once it has been off for `cfg_qr_timeout` cycles. The off-phase therefore lasts exactly `cfg_qr_timeout` cycles.
- R7: `qr_force_cnt` rises by one at each forced start, in the same cycle as the turn-on. It never changes otherwise and saturates at 2^FCNT_W-1.
- R8: The reference PWM period is 2^REF_W cycles, and the period counter is 0 in the first cycle after reset. `ref_pwm` is high for exactly the first D cycles of each period, where D is the active duty value.
- R9: A duty value written with `ref_duty_wr` becomes active at the start of the next reference period. This includes a write in the last cycle of a period. The period in progress keeps its old duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_qr_en | input | 1 | 1 selects quasi-resonant start, 0 selects fixed-frequency start |
| cfg_period | input | TIME_W | Fixed-frequency period in cycles (at least 2) |
| cfg_ton_max | input | TIME_W | Maximum on-time in cycles (at least 1) |
| cfg_toff_min | input | TIME_W | Minimum off-time in cycles |
| cfg_blank | input | BLANK_W | Comparator blanking cycles after turn-on |
| cfg_qr_timeout | input | TIME_W | Quasi-resonant wait limit in off cycles (at least `cfg_toff_min`) |
| cmp_trip_a | input | 1 | Asynchronous peak-current comparator output, 1 = tripped |
| demag_a | input | 1 | Asynchronous demagnetization indication; its rising edge is used |
| ref_duty | input | REF_W | Reference PWM duty value |
| ref_duty_wr | input | 1 | Loads `ref_duty` into the duty buffer |
| sw_drv | output | 1 | Power switch drive, 1 = switch on |
| ref_pwm | output | 1 | Reference PWM for external filtering |
| qr_force_cnt | output | FCNT_W | Count of forced quasi-resonant starts |

## Verification
The bench holds the comparator high across blanking values near and above the maximum on-time. An off-by-one blank counter would show up as a pulse one cycle too long or too short, and a missing blank would give one-cycle pulses. Period and minimum off-time are set right at the point where a tick becomes admissible, so a design that queued a blocked tick instead of skipping it would produce an interval that is not the doubled one. In quasi-resonant mode, a demagnetization edge arrives before the minimum off-time; a design that latched it would start early rather than wait out the timeout. The forced-start counter is also driven into saturation. Duty writes land both mid-period and in the final cycle of a period, which catches a buffer that loads immediately or one that misses the boundary write.

// File: rtl/boost_pkg.sv
package boost_pkg;
   // switch phase of the boost power stage
   typedef enum logic {
      PH_OFF = 1'b0,
      PH_ON  = 1'b1
   } phase_e;
endpackage

// File: rtl/bpc_sync.sv
module bpc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_a,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain <= '0;
            else        chain <= d_a;
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d_a};
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/bpc_tick_gen.sv
module bpc_tick_gen #(
   parameter int TIME_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] period,
   output logic              tick
);
   logic [TIME_W-1:0] cnt;

   assign tick = (cnt >= period - 1'b1);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + 1'b1;
endmodule

// File: rtl/bpc_ref_dac.sv
module bpc_ref_dac #(
   parameter int REF_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REF_W-1:0] duty_in,
   input  logic             duty_wr,
   output logic             pwm_o
);
   logic [REF_W-1:0] pos;
   logic [REF_W-1:0] shadow;
   logic [REF_W-1:0] active;
   logic             wrap;

   assign wrap  = &pos;
   assign pwm_o = (pos < active);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         pos    <= '0;
         shadow <= '0;
         active <= '0;
      end else begin
         pos <= pos + 1'b1;
         if (duty_wr) shadow <= duty_in;
         // a write seen in the last cycle still makes the next period
         if (wrap) active <= duty_wr ? duty_in : shadow;
      end
endmodule

// File: rtl/bpc_switch_seq.sv
module bpc_switch_seq
   import boost_pkg::*;
#(
   parameter int TIME_W  = 12,
   parameter int BLANK_W = 6,
   parameter int FCNT_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               qr_en,
   input  logic               tick,
   input  logic               trip_s,
   input  logic               demag_rise,
   input  logic [TIME_W-1:0]  ton_max,
   input  logic [TIME_W-1:0]  toff_min,
   input  logic [TIME_W-1:0]  qr_timeout,
   input  logic [BLANK_W-1:0] blank_len,
   output logic               sw_on,
   output logic [FCNT_W-1:0]  force_cnt
);
   phase_e             phase;
   logic [TIME_W-1:0]  on_cnt;
   logic [TIME_W-1:0]  off_cnt;
   logic [BLANK_W-1:0] blank_cnt;
   logic               trip_ok;
   logic               on_done;
   logic               off_ok;
   logic               tmo_hit;
   logic               start;
   logic               forced;

   always_comb begin
      trip_ok = trip_s && (blank_cnt == '0);
      on_done = trip_ok || (on_cnt >= ton_max);
      off_ok  = (off_cnt >= toff_min);
      tmo_hit = (off_cnt >= qr_timeout);
      start   = (phase == PH_OFF) && off_ok &&
                (qr_en ? (demag_rise || tmo_hit) : tick);
      forced  = start && qr_en && !demag_rise;
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         phase     <= PH_OFF;
         on_cnt    <= '0;
         off_cnt   <= TIME_W'(1);
         blank_cnt <= '0;
         force_cnt <= '0;
      end else begin
         case (phase)
            PH_OFF: begin
               if (start) begin
                  phase     <= PH_ON;
                  on_cnt    <= TIME_W'(1);
                  blank_cnt <= blank_len;
               end else if (off_cnt != '1) begin
                  off_cnt <= off_cnt + 1'b1;
               end
            end
            PH_ON: begin
               if (on_done) begin
                  phase   <= PH_OFF;
                  off_cnt <= TIME_W'(1);
               end else begin
                  on_cnt <= on_cnt + 1'b1;
                  if (blank_cnt != '0) blank_cnt <= blank_cnt - 1'b1;
               end
            end
            default: phase <= PH_OFF;
         endcase
         if (forced && (force_cnt != '1)) force_cnt <= force_cnt + 1'b1;
      end

   assign sw_on = (phase == PH_ON);
endmodule

// File: rtl/boost_pcm_ctrl.sv
module boost_pcm_ctrl #(
   parameter int TIME_W      = 12,
   parameter int BLANK_W     = 6,
   parameter int REF_W       = 8,
   parameter int FCNT_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_qr_en,
   input  logic [TIME_W-1:0]  cfg_period,
   input  logic [TIME_W-1:0]  cfg_ton_max,
   input  logic [TIME_W-1:0]  cfg_toff_min,
   input  logic [BLANK_W-1:0] cfg_blank,
   input  logic [TIME_W-1:0]  cfg_qr_timeout,
   input  logic               cmp_trip_a,
   input  logic               demag_a,
   input  logic [REF_W-1:0]   ref_duty,
   input  logic               ref_duty_wr,
   output logic               sw_drv,
   output logic               ref_pwm,
   output logic [FCNT_W-1:0]  qr_force_cnt
);
   localparam int N_ASYNC = 2;
   localparam int IDX_CMP = 0;
   localparam int IDX_DMG = 1;

   // elaboration-time parameter checks
   if (TIME_W < 2)       begin : g_chk_time  $error("TIME_W must be at least 2");       end
   if (BLANK_W < 1)      begin : g_chk_blank $error("BLANK_W must be at least 1");      end
   if (REF_W < 2)        begin : g_chk_ref   $error("REF_W must be at least 2");        end
   if (FCNT_W < 1)       begin : g_chk_fcnt  $error("FCNT_W must be at least 1");       end
   if (SYNC_STAGES < 2)  begin : g_chk_sync  $error("SYNC_STAGES must be at least 2"); end
   if (BLANK_W > TIME_W) begin : g_chk_bw    $error("BLANK_W must not exceed TIME_W"); end

   logic [N_ASYNC-1:0] async_in;
   logic [N_ASYNC-1:0] sync_out;
   logic               demag_prev;
   logic               demag_rise;
   logic               tick;

   assign async_in[IDX_CMP] = cmp_trip_a;
   assign async_in[IDX_DMG] = demag_a;

   for (genvar i = 0; i < N_ASYNC; i++) begin : g_sync
      bpc_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d_a   (async_in[i]),
         .q     (sync_out[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) demag_prev <= 1'b0;
      else        demag_prev <= sync_out[IDX_DMG];

   assign demag_rise = sync_out[IDX_DMG] && !demag_prev;

   bpc_tick_gen #(.TIME_W(TIME_W)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .period (cfg_period),
      .tick   (tick)
   );

   bpc_switch_seq #(
      .TIME_W  (TIME_W),
      .BLANK_W (BLANK_W),
      .FCNT_W  (FCNT_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .qr_en      (cfg_qr_en),
      .tick       (tick),
      .trip_s     (sync_out[IDX_CMP]),
      .demag_rise (demag_rise),
      .ton_max    (cfg_ton_max),
      .toff_min   (cfg_toff_min),
      .qr_timeout (cfg_qr_timeout),
      .blank_len  (cfg_blank),
      .sw_on      (sw_drv),
      .force_cnt  (qr_force_cnt)
   );

   bpc_ref_dac #(.REF_W(REF_W)) u_ref (
      .clk     (clk),
      .rst_n   (rst_n),
      .duty_in (ref_duty),
      .duty_wr (ref_duty_wr),
      .pwm_o   (ref_pwm)
   );
endmodule

// File: rtl/boost_pcm_ctrl_chk.sv
module boost_pcm_ctrl_chk #(
   parameter int TIME_W  = 12,
   parameter int BLANK_W = 6,
   parameter int FCNT_W  = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic [TIME_W-1:0]  cfg_ton_max,
   input logic [TIME_W-1:0]  cfg_toff_min,
   input logic [BLANK_W-1:0] cfg_blank,
   input logic               sw_drv,
   input logic [FCNT_W-1:0]  qr_force_cnt
);
   localparam int LW = TIME_W + 1;

   logic [LW-1:0] hi_run;
   logic [LW-1:0] lo_run;
   logic [LW-1:0] ton_ext;
   logic [LW-1:0] toff_ext;
   logic [LW-1:0] blank_pl1;
   logic [LW-1:0] min_hi;

   assign ton_ext   = LW'(cfg_ton_max);
   assign toff_ext  = LW'(cfg_toff_min);
   assign blank_pl1 = LW'(cfg_blank) + LW'(1);
   assign min_hi    = (blank_pl1 < ton_ext) ? blank_pl1 : ton_ext;

   // observed run lengths of the switch drive
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         hi_run <= '0;
         lo_run <= '0;
      end else if (sw_drv) begin
         hi_run <= (&hi_run) ? hi_run : hi_run + 1'b1;
         lo_run <= '0;
      end else begin
         lo_run <= (&lo_run) ? lo_run : lo_run + 1'b1;
         hi_run <= '0;
      end

   AST_ON_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      sw_drv |-> (hi_run < ton_ext)); // R2

   AST_BLANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sw_drv) |-> (hi_run >= min_hi)); // R3

   AST_MIN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sw_drv) |-> (lo_run >= toff_ext)); // R4

   AST_FORCE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (qr_force_cnt != $past(qr_force_cnt)) |->
         ((qr_force_cnt == $past(qr_force_cnt) + 1'b1) && $rose(sw_drv))); // R7
endmodule

bind boost_pcm_ctrl boost_pcm_ctrl_chk #(
   .TIME_W  (TIME_W),
   .BLANK_W (BLANK_W),
   .FCNT_W  (FCNT_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_ton_max  (cfg_ton_max),
   .cfg_toff_min (cfg_toff_min),
   .cfg_blank    (cfg_blank),
   .sw_drv       (sw_drv),
   .qr_force_cnt (qr_force_cnt)
);

// File: tb/boost_pcm_ctrl_tb_top.sv
module boost_pcm_ctrl_tb_top;
   localparam int TIME_W  = 12;
   localparam int BLANK_W = 6;
   localparam int REF_W   = 8;
   localparam int FCNT_W  = 8;
   localparam int RPER    = 1 << REF_W;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               cfg_qr_en = 1'b0;
   logic [TIME_W-1:0]  cfg_period = 12'd40;
   logic [TIME_W-1:0]  cfg_ton_max = 12'd10;
   logic [TIME_W-1:0]  cfg_toff_min = 12'd3;
   logic [BLANK_W-1:0] cfg_blank = '0;
   logic [TIME_W-1:0]  cfg_qr_timeout = 12'd100;
   logic               cmp_trip_a = 1'b0;
   logic               demag_a = 1'b0;
   logic [REF_W-1:0]   ref_duty = '0;
   logic               ref_duty_wr = 1'b0;
   logic               sw_drv;
   logic               ref_pwm;
   logic [FCNT_W-1:0]  qr_force_cnt;

   int n_chk  = 0;
   int n_fail = 0;

   always #2 clk = ~clk; // 250 MHz

   boost_pcm_ctrl #(
      .TIME_W(TIME_W), .BLANK_W(BLANK_W), .REF_W(REF_W), .FCNT_W(FCNT_W), .SYNC_STAGES(2)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_qr_en(cfg_qr_en), .cfg_period(cfg_period),
      .cfg_ton_max(cfg_ton_max), .cfg_toff_min(cfg_toff_min), .cfg_blank(cfg_blank),
      .cfg_qr_timeout(cfg_qr_timeout), .cmp_trip_a(cmp_trip_a), .demag_a(demag_a),
      .ref_duty(ref_duty), .ref_duty_wr(ref_duty_wr), .sw_drv(sw_drv),
      .ref_pwm(ref_pwm), .qr_force_cnt(qr_force_cnt)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      report();
      $finish;
   end

   task automatic restart(input bit qr, input int per, input int ton, input int toff,
                          input int blank, input int tmo, input bit trip);
      @(negedge clk);
      rst_n          = 1'b0;
      cfg_qr_en      = qr;
      cfg_period     = TIME_W'(per);
      cfg_ton_max    = TIME_W'(ton);
      cfg_toff_min   = TIME_W'(toff);
      cfg_blank      = BLANK_W'(blank);
      cfg_qr_timeout = TIME_W'(tmo);
      cmp_trip_a     = trip;
      demag_a        = 1'b0;
      ref_duty_wr    = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wait_rise();
      bit prev;
      prev = sw_drv;
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk);
         if (!prev && sw_drv) break;
         prev = sw_drv;
      end
   endtask

   // called at the first negedge where sw_drv is 1; returns at the first low one
   task automatic measure_high(output int n);
      n = 1;
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk);
         if (!sw_drv) break;
         n++;
      end
   endtask

   task automatic measure_low(output int n);
      n = 1;
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk);
         if (sw_drv) break;
         n++;
      end
   endtask

   function automatic int exp_high(input int ton, input int blank, input bit trip);
      if (trip && (blank + 1 < ton)) return blank + 1;
      return ton;
   endfunction

   task automatic fixed_run(input int per, input int ton, input int toff, input int blank,
                            input bit trip, input int exp_i, input string tag);
      int h;
      int l;
      restart(1'b0, per, ton, toff, blank, 100, trip);
      wait_rise();
      measure_high(h);
      measure_low(l);
      measure_high(h);
      measure_low(l);
      check(h == exp_high(ton, blank, trip), {tag, " on-time"}, h, exp_high(ton, blank, trip));
      check(h + l == exp_i, {tag, " interval R4"}, h + l, exp_i);
   endtask

   // samples one reference period starting at position 0; optional write at wr_idx
   task automatic ref_window(input int wr_idx, input int wr_val, output int hi, output bit prefix);
      bit seen_low;
      hi       = 0;
      prefix   = 1'b1;
      seen_low = 1'b0;
      for (int i = 0; i < RPER; i++) begin
         ref_duty_wr = (i == wr_idx);
         if (i == wr_idx) ref_duty = REF_W'(wr_val);
         if (ref_pwm) begin
            hi++;
            if (seen_low) prefix = 1'b0;
         end else begin
            seen_low = 1'b1;
         end
         @(negedge clk);
      end
      ref_duty_wr = 1'b0;
   endtask

   initial begin
      int lat;
      int h;
      int n;
      int hi;
      bit pre;
      int d_prev;
      int d_new;
      void'($urandom(32'd20240611));

      // R1: reset state
      restart(1'b0, 200, 10, 3, 0, 100, 1'b0);
      check(sw_drv == 1'b0, "R1 sw_drv", sw_drv, 0);
      @(negedge clk);
      check(sw_drv == 1'b0, "R1 sw_drv after release", sw_drv, 0);
      check(ref_pwm == 1'b0, "R1 ref_pwm", ref_pwm, 0);
      check(qr_force_cnt == '0, "R1 force count", qr_force_cnt, 0);

      // fixed-frequency directed cases
      fixed_run(40, 10, 3, 4, 1'b0, 40, "R2 no trip");
      fixed_run(40, 10, 3, 4, 1'b1, 40, "R3 blank 4");
      fixed_run(40, 10, 3, 0, 1'b1, 40, "R3 blank 0");
      fixed_run(40, 3, 3, 7, 1'b1, 40, "R3 R2 blank beyond ton");
      fixed_run(12, 10, 2, 0, 1'b0, 12, "R4 toff at limit");
      fixed_run(12, 10, 3, 0, 1'b0, 24, "R4 tick skipped");

      // randomized fixed-frequency runs
      for (int k = 0; k < 6; k++) begin
         int ton;
         int bl;
         int toff;
         int per;
         bit trip;
         ton  = $urandom_range(2, 20);
         bl   = $urandom_range(0, 15);
         toff = $urandom_range(1, 8);
         per  = ton + toff + $urandom_range(0, 10);
         trip = 1'($urandom_range(0, 1));
         fixed_run(per, ton, toff, bl, trip, per, "R2 R3 random");
      end

      // R5: demagnetization start latency
      restart(1'b1, 50, 8, 4, 2, 200, 1'b0);
      repeat (10) @(negedge clk);
      demag_a = 1'b1;
      lat = 0;
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         lat++;
         if (sw_drv) break;
      end
      check(lat == 3, "R5 demag latency", lat, 3);
      measure_high(h);
      check(h == 8, "R2 qr on-time", h, 8);
      demag_a = 1'b0;
      repeat (10) @(negedge clk);
      demag_a = 1'b1;
      lat = 0;
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         lat++;
         if (sw_drv) break;
      end
      check(lat == 3, "R5 second demag latency", lat, 3);
      check(qr_force_cnt == '0, "R7 no forced start", qr_force_cnt, 0);

      // R5 early edge ignored, R6 timeout
      restart(1'b1, 50, 8, 20, 2, 60, 1'b0);
      wait_rise();
      check(qr_force_cnt == FCNT_W'(1), "R7 first forced start", qr_force_cnt, 1);
      measure_high(h);
      n = 1;
      for (int i = 0; i < 20000; i++) begin
         if (n == 2) demag_a = 1'b1;
         @(negedge clk);
         if (sw_drv) break;
         n++;
      end
      check(n == 60, "R6 R5 off length with early edge", n, 60);
      check(qr_force_cnt == FCNT_W'(2), "R7 second forced start", qr_force_cnt, 2);
      demag_a = 1'b0;

      // R7 saturation
      restart(1'b1, 50, 2, 1, 0, 3, 1'b0);
      repeat (1800) @(negedge clk);
      check(qr_force_cnt == '1, "R7 saturation", qr_force_cnt, 255);

      // R8 R9 reference PWM
      restart(1'b0, 200, 10, 3, 0, 100, 1'b0);
      repeat (RPER) @(negedge clk);
      ref_window(10, 100, hi, pre);
      check(hi == 0, "R9 mid-period write deferred", hi, 0);
      ref_window(-1, 0, hi, pre);
      check(hi == 100, "R8 duty 100", hi, 100);
      check(pre, "R8 high at period start", pre, 1);
      ref_window(RPER - 1, 255, hi, pre);
      check(hi == 100, "R9 last-cycle write deferred", hi, 100);
      ref_window(5, 0, hi, pre);
      check(hi == 255, "R9 R8 last-cycle write lands", hi, 255);
      ref_window(-1, 0, hi, pre);
      check(hi == 0, "R8 duty 0", hi, 0);
      d_prev = 0;
      for (int k = 0; k < 4; k++) begin
         d_new = $urandom_range(0, RPER - 1);
         ref_window($urandom_range(0, RPER - 1), d_new, hi, pre);
         check(hi == d_prev, "R9 random deferred", hi, d_prev);
         ref_window(-1, 0, hi, pre);
         check(hi == d_new && pre, "R8 random duty", hi, d_new);
         d_prev = d_new;
      end

      report();
      $finish;
   end
endmodule